// File: doc/BRIEF.md
# Directory Home Coherence Controller

This block is the home node for a small memory region shared by several caching sites. Each memory block has one directory entry. The entry records whether the block is clean and which sites share it, or whether one site owns it modified. Sites send read and write requests and protocol replies on a valid/ready input port. The controller answers on a matching output port with grants, invalidation asks, writeback asks and flush asks. A local data array stands in for the memory bank and takes the data that owners return.

Transactions are handled one at a time. A write to a shared block invalidates the other sharers one message at a time. The block then waits in an invalidation-wait state until every acknowledgement has arrived. A read or write to a modified block recalls the data from the owner, and the block waits in a writeback-wait state until that data comes back. The interconnect is assumed reliable and in order between any pair of endpoints.

Top module: `home_dir_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is low, every block is clean with no sharers, and block i holds data value i.
- R2: A read request (in_type 0) to a clean block is answered at once by a read grant (out_type 0) to the requester. The grant carries the block's memory data, and the requester joins the sharer set.
- R3: A read request to a modified block sends a writeback ask (out_type 3) to the owner. A writeback reply (in_type 2) from that owner writes memory and sends a read grant with the returned data to the requester. Owner and requester are then the only sharers.
- R4: A write request (in_type 1) to a clean block whose sharers include sites other than the requester sends one invalidation ask (out_type 2) to each of those sites, in ascending site order. The requester never gets one. Only after an acknowledgement (in_type 3) from every one of them is a write grant (out_type 1) with memory data sent, and the block becomes owned by the requester.
- R5: A write request to a clean block with no sharer other than the requester gets an immediate write grant with memory data, and the block becomes owned by the requester.
- R6: A write request to a modified block sends a flush ask (out_type 4) to the owner, even when the owner is the requester. A flush reply (in_type 4) from that owner writes memory and sends a write grant with the returned data to the requester, who becomes the owner.
- R7: While a transaction waits on invalidation acknowledgements or on an owner's data, `in_ready` stays low for read and write requests.
- R8: A reply that does not match the outstanding transaction is consumed with no effect. This covers an unsolicited reply, one of the wrong type, one from the wrong site, one for another block, and a repeated acknowledgement.
- R9: While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R10: Ask messages (out_type 2, 3, 4) carry zero data; grants carry the block's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Incoming message taken on this edge |
| in_type | input | 3 | 0 read req, 1 write req, 2 writeback reply, 3 inval ack, 4 flush reply |
| in_src | input | SITE_W | Sending site |
| in_addr | input | ADDR_W | Block index |
| in_data | input | DATA_W | Returned block data for replies |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Receiver takes the outgoing message |
| out_type | output | 3 | 0 read grant, 1 write grant, 2 inval ask, 3 writeback ask, 4 flush ask |
| out_dest | output | SITE_W | Destination site |
| out_addr | output | ADDR_W | Block index |
| out_data | output | DATA_W | Block data on grants, zero on asks |

## Verification
The bench targets writes that must invalidate several sharers. A design that grants early or skips a sharer shows up as an early or missing message. Stray acknowledgements, wrong-block replies and a reply of the wrong kind are sent during the wait states; a design that counts them would release the write grant too soon, and one that takes the wrong kind would answer with the wrong grant. It probes request acceptance while a block is transient, where a leaky ready would start a second transaction. It also covers an owner that re-requests its own block. Output back-pressure is applied throughout, so a slot that drops or changes a stalled message is caught.

// File: rtl/hcc_pkg.sv
// Shared message and state encodings for the home coherence controller.
// Assumes the message type field is 3 bits wide on both ports.
package hcc_pkg;

    typedef enum logic [2:0] {
        IN_RD_ASK     = 3'd0,
        IN_WR_ASK     = 3'd1,
        IN_WB_DATA    = 3'd2,
        IN_INV_ACK    = 3'd3,
        IN_FLUSH_DATA = 3'd4
    } in_msg_e;

    typedef enum logic [2:0] {
        OUT_RD_GRANT  = 3'd0,
        OUT_WR_GRANT  = 3'd1,
        OUT_INV_ASK   = 3'd2,
        OUT_WB_ASK    = 3'd3,
        OUT_FLUSH_ASK = 3'd4
    } out_msg_e;

    // Stable: clean-shared and owned; transient: waiting on acks or owner data.
    typedef enum logic [1:0] {
        D_CLEAN    = 2'd0,
        D_OWNED    = 2'd1,
        D_INV_WAIT = 2'd2,
        D_WB_WAIT  = 2'd3
    } dir_state_e;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_INV  = 2'd1,
        C_WAIT = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/hcc_first_set.sv
// Lowest-set-bit finder used to order invalidation asks by site id.
// Assumes W >= 1; found is low when the vector is empty.
module hcc_first_set #(
    parameter int W = 4,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hcc_dir_table.sv
// Directory entries plus the backing data array, one row per block.
// Two combinational read ports (request decode and outstanding block),
// one entry write port and one data write port per cycle.
// Assumes N_BLOCKS is a power of two so every address is in range.
module hcc_dir_table
    import hcc_pkg::*;
#(
    parameter int N_SITES  = 4,
    parameter int N_BLOCKS = 8,
    parameter int DATA_W   = 16,
    localparam int SITE_W  = (N_SITES > 1) ? $clog2(N_SITES) : 1,
    localparam int ADDR_W  = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  ra_addr,
    output dir_state_e         ra_st,
    output logic [N_SITES-1:0] ra_share,
    output logic [SITE_W-1:0]  ra_owner,
    output logic [DATA_W-1:0]  ra_data,
    input  logic [ADDR_W-1:0]  rb_addr,
    output dir_state_e         rb_st,
    output logic [DATA_W-1:0]  rb_data,
    input  logic               we,
    input  logic [ADDR_W-1:0]  w_addr,
    input  dir_state_e         w_st,
    input  logic [N_SITES-1:0] w_share,
    input  logic [SITE_W-1:0]  w_owner,
    input  logic               dwe,
    input  logic [ADDR_W-1:0]  dw_addr,
    input  logic [DATA_W-1:0]  dw_data
);

    dir_state_e         st_q    [N_BLOCKS];
    logic [N_SITES-1:0] share_q [N_BLOCKS];
    logic [SITE_W-1:0]  owner_q [N_BLOCKS];
    logic [DATA_W-1:0]  data_q  [N_BLOCKS];

    // Entry and data update; reset leaves every block clean, holding its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BLOCKS; i++) begin
                st_q[i]    <= D_CLEAN;
                share_q[i] <= '0;
                owner_q[i] <= '0;
                data_q[i]  <= DATA_W'(i);
            end
        end else begin
            if (we) begin
                st_q[w_addr]    <= w_st;
                share_q[w_addr] <= w_share;
                owner_q[w_addr] <= w_owner;
            end
            if (dwe) begin
                data_q[dw_addr] <= dw_data;
            end
        end
    end

    assign ra_st    = st_q[ra_addr];
    assign ra_share = share_q[ra_addr];
    assign ra_owner = owner_q[ra_addr];
    assign ra_data  = data_q[ra_addr];
    assign rb_st    = st_q[rb_addr];
    assign rb_data  = data_q[rb_addr];

endmodule

// File: rtl/hcc_out_slot.sv
// Single-entry output register for outgoing messages.
// A load is only issued when slot_free is high; the entry holds while stalled.
module hcc_out_slot
    import hcc_pkg::*;
#(
    parameter int SITE_W = 2,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  out_msg_e          ld_type,
    input  logic [SITE_W-1:0] ld_dest,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              out_ready,
    output logic              slot_free,
    output logic              out_valid,
    output logic [2:0]        out_type,
    output logic [SITE_W-1:0] out_dest,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    // Capture a new message or retire the current one on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_type  <= '0;
            out_dest  <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (ld) begin
            out_valid <= 1'b1;
            out_type  <= ld_type;
            out_dest  <= ld_dest;
            out_addr  <= ld_addr;
            out_data  <= ld_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign slot_free = !out_valid || out_ready;

endmodule

// File: rtl/home_dir_ctrl.sv
// Home-node directory controller. Serialises read/write requests from
// N_SITES caching sites, tracks sharers or a modified owner per block,
// recalls and invalidates copies, and returns grants with block data.
// Assumes a reliable, per-pair in-order network; one transaction at a time.
module home_dir_ctrl
    import hcc_pkg::*;
#(
    parameter int N_SITES  = 4,
    parameter int N_BLOCKS = 8,
    parameter int DATA_W   = 16,
    localparam int SITE_W  = (N_SITES > 1) ? $clog2(N_SITES) : 1,
    localparam int ADDR_W  = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_type,
    input  logic [SITE_W-1:0] in_src,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_type,
    output logic [SITE_W-1:0] out_dest,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    localparam int CNT_W = $clog2(N_SITES + 1);

    ctrl_state_e        cs, cs_n;
    logic [ADDR_W-1:0]  t_addr, t_addr_n;
    logic [SITE_W-1:0]  t_req, t_req_n;
    logic [SITE_W-1:0]  t_owner, t_owner_n;
    logic               t_excl, t_excl_n;
    logic [N_SITES-1:0] inv_left, inv_left_n;
    logic [N_SITES-1:0] ack_wait, ack_wait_n;
    logic [CNT_W-1:0]   ack_cnt, ack_cnt_n;

    dir_state_e         a_st, b_st;
    logic [N_SITES-1:0] a_share;
    logic [SITE_W-1:0]  a_owner;
    logic [DATA_W-1:0]  a_data, b_data;

    logic               we, dwe;
    dir_state_e         w_st;
    logic [N_SITES-1:0] w_share;
    logic [SITE_W-1:0]  w_owner;
    logic [ADDR_W-1:0]  w_addr;

    logic               ld, slot_free;
    out_msg_e           ld_type;
    logic [SITE_W-1:0]  ld_dest;
    logic [ADDR_W-1:0]  ld_addr;
    logic [DATA_W-1:0]  ld_data;

    logic [SITE_W-1:0]  pick_idx;
    logic               pick_found;

    logic [N_SITES-1:0] src_bit, others;
    logic [CNT_W-1:0]   others_cnt;
    logic               is_req, a_transient, acc, hit_blk;

    hcc_dir_table #(
        .N_SITES (N_SITES),
        .N_BLOCKS(N_BLOCKS),
        .DATA_W  (DATA_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (in_addr),
        .ra_st   (a_st),
        .ra_share(a_share),
        .ra_owner(a_owner),
        .ra_data (a_data),
        .rb_addr (t_addr),
        .rb_st   (b_st),
        .rb_data (b_data),
        .we      (we),
        .w_addr  (w_addr),
        .w_st    (w_st),
        .w_share (w_share),
        .w_owner (w_owner),
        .dwe     (dwe),
        .dw_addr (t_addr),
        .dw_data (in_data)
    );

    hcc_first_set #(.W(N_SITES)) u_pick (
        .vec  (inv_left),
        .idx  (pick_idx),
        .found(pick_found)
    );

    hcc_out_slot #(
        .SITE_W(SITE_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld),
        .ld_type  (ld_type),
        .ld_dest  (ld_dest),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .out_ready(out_ready),
        .slot_free(slot_free),
        .out_valid(out_valid),
        .out_type (out_type),
        .out_dest (out_dest),
        .out_addr (out_addr),
        .out_data (out_data)
    );

    // Request decode helpers and the sharers that a write must invalidate.
    always_comb begin
        src_bit     = N_SITES'(1) << in_src;
        others      = a_share & ~src_bit;
        is_req      = (in_type == IN_RD_ASK) || (in_type == IN_WR_ASK);
        a_transient = (a_st == D_INV_WAIT) || (a_st == D_WB_WAIT);
        hit_blk     = (in_addr == t_addr);
        others_cnt  = '0;
        for (int i = 0; i < N_SITES; i++) begin
            others_cnt = others_cnt + CNT_W'(others[i]);
        end
    end

    // Requests only when idle on a stable block; replies except while issuing invals.
    always_comb begin
        if (is_req) in_ready = slot_free && (cs == C_IDLE) && !a_transient;
        else        in_ready = slot_free && (cs != C_INV);
        acc = in_valid && in_ready;
    end

    // Protocol sequencing: directory update, next message and transaction state.
    always_comb begin
        cs_n       = cs;
        t_addr_n   = t_addr;
        t_req_n    = t_req;
        t_owner_n  = t_owner;
        t_excl_n   = t_excl;
        inv_left_n = inv_left;
        ack_wait_n = ack_wait;
        ack_cnt_n  = ack_cnt;
        we         = 1'b0;
        w_addr     = (cs == C_IDLE) ? in_addr : t_addr;
        w_st       = D_CLEAN;
        w_share    = '0;
        w_owner    = '0;
        dwe        = 1'b0;
        ld         = 1'b0;
        ld_type    = OUT_RD_GRANT;
        ld_dest    = '0;
        ld_addr    = (cs == C_IDLE) ? in_addr : t_addr;
        ld_data    = '0;
        case (cs)
            C_IDLE: begin
                if (acc && is_req) begin
                    t_addr_n  = in_addr;
                    t_req_n   = in_src;
                    t_owner_n = a_owner;
                    t_excl_n  = (in_type == IN_WR_ASK);
                    if (a_st == D_OWNED) begin
                        ld      = 1'b1;
                        ld_type = (in_type == IN_WR_ASK) ? OUT_FLUSH_ASK : OUT_WB_ASK;
                        ld_dest = a_owner;
                        we      = 1'b1;
                        w_st    = D_WB_WAIT;
                        w_owner = a_owner;
                        cs_n    = C_WAIT;
                    end else if (in_type == IN_RD_ASK) begin
                        ld      = 1'b1;
                        ld_type = OUT_RD_GRANT;
                        ld_dest = in_src;
                        ld_data = a_data;
                        we      = 1'b1;
                        w_st    = D_CLEAN;
                        w_share = a_share | src_bit;
                    end else if (others == '0) begin
                        ld      = 1'b1;
                        ld_type = OUT_WR_GRANT;
                        ld_dest = in_src;
                        ld_data = a_data;
                        we      = 1'b1;
                        w_st    = D_OWNED;
                        w_owner = in_src;
                    end else begin
                        we         = 1'b1;
                        w_st       = D_INV_WAIT;
                        w_share    = others;
                        inv_left_n = others;
                        ack_wait_n = others;
                        ack_cnt_n  = others_cnt;
                        cs_n       = C_INV;
                    end
                end
            end
            C_INV: begin
                if (slot_free && pick_found) begin
                    ld         = 1'b1;
                    ld_type    = OUT_INV_ASK;
                    ld_dest    = pick_idx;
                    inv_left_n = inv_left & ~(N_SITES'(1) << pick_idx);
                    if (inv_left_n == '0) cs_n = C_WAIT;
                end
            end
            C_WAIT: begin
                if (acc && hit_blk) begin
                    if (in_type == IN_INV_ACK && b_st == D_INV_WAIT && ack_wait[in_src]) begin
                        ack_wait_n = ack_wait & ~src_bit;
                        ack_cnt_n  = ack_cnt - CNT_W'(1);
                        if (ack_cnt == CNT_W'(1)) begin
                            ld      = 1'b1;
                            ld_type = OUT_WR_GRANT;
                            ld_dest = t_req;
                            ld_data = b_data;
                            we      = 1'b1;
                            w_st    = D_OWNED;
                            w_owner = t_req;
                            cs_n    = C_IDLE;
                        end
                    end else if (in_type == IN_WB_DATA && b_st == D_WB_WAIT
                                 && !t_excl && in_src == t_owner) begin
                        dwe     = 1'b1;
                        ld      = 1'b1;
                        ld_type = OUT_RD_GRANT;
                        ld_dest = t_req;
                        ld_data = in_data;
                        we      = 1'b1;
                        w_st    = D_CLEAN;
                        w_share = (N_SITES'(1) << t_owner) | (N_SITES'(1) << t_req);
                        cs_n    = C_IDLE;
                    end else if (in_type == IN_FLUSH_DATA && b_st == D_WB_WAIT
                                 && t_excl && in_src == t_owner) begin
                        dwe     = 1'b1;
                        ld      = 1'b1;
                        ld_type = OUT_WR_GRANT;
                        ld_dest = t_req;
                        ld_data = in_data;
                        we      = 1'b1;
                        w_st    = D_OWNED;
                        w_owner = t_req;
                        cs_n    = C_IDLE;
                    end
                end
            end
            default: cs_n = C_IDLE;
        endcase
    end

    // Transaction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs       <= C_IDLE;
            t_addr   <= '0;
            t_req    <= '0;
            t_owner  <= '0;
            t_excl   <= 1'b0;
            inv_left <= '0;
            ack_wait <= '0;
            ack_cnt  <= '0;
        end else begin
            cs       <= cs_n;
            t_addr   <= t_addr_n;
            t_req    <= t_req_n;
            t_owner  <= t_owner_n;
            t_excl   <= t_excl_n;
            inv_left <= inv_left_n;
            ack_wait <= ack_wait_n;
            ack_cnt  <= ack_cnt_n;
        end
    end

endmodule

// File: rtl/hcc_checker.sv
// Protocol checks for home_dir_ctrl, attached by bind below.
// Assumes synchronous active-low reset; all properties hold from reset onward.
module hcc_checker
    import hcc_pkg::*;
#(
    parameter int N_SITES = 4,
    parameter int SITE_W  = 2,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [2:0]         in_type,
    input logic               out_valid,
    input logic               out_ready,
    input logic [2:0]         out_type,
    input logic [SITE_W-1:0]  out_dest,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [DATA_W-1:0]  out_data,
    input ctrl_state_e        cs,
    input logic [SITE_W-1:0]  t_req,
    input logic [N_SITES-1:0] ack_wait,
    input logic [CNT_W-1:0]   ack_cnt
);

    // R1: the cycle after reset is sampled low, nothing is offered.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R9: a stalled message keeps all of its fields.
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dest)
                                    && $stable(out_addr) && $stable(out_data));

    // R7: a request is only taken with no transaction outstanding.
    a_r7_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_type == IN_RD_ASK || in_type == IN_WR_ASK)
        |-> cs == C_IDLE);

    // R4: the acknowledgement counter matches the sites still owing one.
    a_r4_ack_tally: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cnt == CNT_W'($countones(ack_wait)));

    // R4: the writer is never asked to invalidate its own copy.
    a_r4_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_type == OUT_INV_ASK |-> out_dest != t_req);

    // R10: asks carry no data.
    a_r10_ask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_type == OUT_INV_ASK || out_type == OUT_WB_ASK
                      || out_type == OUT_FLUSH_ASK) |-> out_data == '0);

endmodule

bind home_dir_ctrl hcc_checker #(
    .N_SITES(N_SITES),
    .SITE_W (SITE_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  ($clog2(N_SITES + 1))
) u_hcc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_type  (in_type),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_type (out_type),
    .out_dest (out_dest),
    .out_addr (out_addr),
    .out_data (out_data),
    .cs       (cs),
    .t_req    (t_req),
    .ack_wait (ack_wait),
    .ack_cnt  (ack_cnt)
);

// File: tb/home_dir_ctrl_bench.sv
// Bench for home_dir_ctrl: behavioural directory model plus a queue of
// expected outgoing messages, compared on every handshake clock.
module home_dir_ctrl_bench;
    import hcc_pkg::*;

    localparam int N_SITES  = 4;
    localparam int N_BLOCKS = 8;
    localparam int DATA_W   = 16;
    localparam int SITE_W   = 2;
    localparam int ADDR_W   = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [2:0]        in_type;
    logic [SITE_W-1:0] in_src;
    logic [ADDR_W-1:0] in_addr;
    logic [DATA_W-1:0] in_data;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [2:0]        out_type;
    logic [SITE_W-1:0] out_dest;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;

    home_dir_ctrl #(
        .N_SITES (N_SITES),
        .N_BLOCKS(N_BLOCKS),
        .DATA_W  (DATA_W)
    ) u_home_dir_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_type  (in_type),
        .in_src   (in_src),
        .in_addr  (in_addr),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_type (out_type),
        .out_dest (out_dest),
        .out_addr (out_addr),
        .out_data (out_data)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string cur_req = "R1";

    // Model state: 0 clean, 1 owned.
    int       m_st  [N_BLOCKS];
    bit [3:0] m_sh  [N_BLOCKS];
    int       m_own [N_BLOCKS];
    int       m_mem [N_BLOCKS];

    function automatic int pack(int t, int d, int a, int v);
        return (t << 24) | (d << 20) | (a << 16) | (v & 16'hffff);
    endfunction

    function automatic void chk(bit ok, string req, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endfunction

    // Monitor: vary out_ready, check held messages, compare consumed ones.
    int cyc = 0;
    bit prev_v = 1'b0;
    bit prev_r = 1'b1;
    int prev_p = 0;
    bit rdy;
    int act_p;
    int exp_p;
    always @(negedge clk) begin
        cyc++;
        rdy   = !((cyc % 7) == 3 || (cyc % 13) == 6 || (cyc % 13) == 7);
        act_p = pack(out_type, out_dest, out_addr, out_data);
        if (rst_n && prev_v && !prev_r)
            chk(out_valid && act_p == prev_p, "R9", "stalled message held", act_p, prev_p);
        out_ready = rdy;
        if (rst_n && out_valid && rdy) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, "unexpected message", act_p, 0);
            end else begin
                exp_p = exp_q.pop_front();
                chk(act_p == exp_p, cur_req, "message", act_p, exp_p);
            end
        end
        prev_v = rst_n && out_valid;
        prev_r = rdy;
        prev_p = act_p;
    end

    task automatic expect_msg(int t, int d, int a, int v);
        exp_q.push_back(pack(t, d, a, v));
    endtask

    task automatic send(int t, int s, int a, int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_type  = 3'(t);
        in_src   = SITE_W'(s);
        in_addr  = ADDR_W'(a);
        in_data  = DATA_W'(v);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // R7: a request presented during a transient wait is never taken.
    task automatic probe_blocked(int s, int a, int t);
        @(negedge clk);
        in_valid = 1'b1;
        in_type  = 3'(t);
        in_src   = SITE_W'(s);
        in_addr  = ADDR_W'(a);
        in_data  = '0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(!in_ready, "R7", "request ready while transient", in_ready, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic do_rd(int s, int a, int wbv);
        int o;
        if (m_st[a] == 1) begin
            o = m_own[a];
            expect_msg(OUT_WB_ASK, o, a, 0);
            send(IN_RD_ASK, s, a, 0);
            drain();
            probe_blocked((s + 1) % N_SITES, a, IN_WR_ASK);
            send(IN_FLUSH_DATA, o, a, 16'hdead);     // R8: wrong kind, dropped
            repeat (3) @(negedge clk);
            expect_msg(OUT_RD_GRANT, s, a, wbv);
            send(IN_WB_DATA, o, a, wbv);
            m_mem[a] = wbv;
            m_sh[a]  = 4'(1 << o) | 4'(1 << s);
            m_st[a]  = 0;
        end else begin
            expect_msg(OUT_RD_GRANT, s, a, m_mem[a]);
            send(IN_RD_ASK, s, a, 0);
            m_sh[a] = m_sh[a] | 4'(1 << s);
        end
        drain();
    endtask

    task automatic do_wr(int s, int a, int fv, bit stray);
        int o;
        int left;
        bit [3:0] oth;
        bit first;
        if (m_st[a] == 1) begin
            o = m_own[a];
            expect_msg(OUT_FLUSH_ASK, o, a, 0);
            send(IN_WR_ASK, s, a, 0);
            drain();
            probe_blocked(s, a, IN_RD_ASK);
            expect_msg(OUT_WR_GRANT, s, a, fv);
            send(IN_FLUSH_DATA, o, a, fv);
            m_mem[a] = fv;
        end else begin
            oth = m_sh[a] & ~4'(1 << s);
            if (oth == 0) begin
                expect_msg(OUT_WR_GRANT, s, a, m_mem[a]);
                send(IN_WR_ASK, s, a, 0);
            end else begin
                left = 0;
                for (int i = 0; i < N_SITES; i++) begin
                    if (oth[i]) begin
                        expect_msg(OUT_INV_ASK, i, a, 0);
                        left++;
                    end
                end
                send(IN_WR_ASK, s, a, 0);
                drain();
                probe_blocked(s, a, IN_RD_ASK);
                if (stray) begin
                    send(IN_INV_ACK, s, a, 0);                   // R8: not a sharer
                    send(IN_INV_ACK, $clog2(oth + 1) - 1, (a + 1) % N_BLOCKS, 0); // other block
                    repeat (3) @(negedge clk);
                end
                first = 1'b1;
                for (int i = N_SITES - 1; i >= 0; i--) begin
                    if (oth[i]) begin
                        if (left == 1) expect_msg(OUT_WR_GRANT, s, a, m_mem[a]);
                        send(IN_INV_ACK, i, a, 0);
                        left--;
                        if (stray && first && left > 0) begin
                            send(IN_INV_ACK, i, a, 0);           // R8: repeated ack
                            repeat (3) @(negedge clk);
                        end
                        first = 1'b0;
                    end
                end
            end
        end
        m_st[a]  = 1;
        m_own[a] = s;
        m_sh[a]  = 0;
        drain();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N_BLOCKS; i++) begin
            m_st[i]  = 0;
            m_sh[i]  = 0;
            m_own[i] = 0;
            m_mem[i] = i;
        end
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_type  = '0;
        in_src   = '0;
        in_addr  = '0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(in_ready, "R1", "ready after reset", in_ready, 1);
        chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);

        cur_req = "R1";
        do_rd(0, 0, 0);
        do_rd(1, 5, 0);
        cur_req = "R2";
        do_rd(2, 0, 0);
        do_rd(3, 0, 0);
        cur_req = "R4";
        do_wr(1, 0, 0, 1'b1);
        cur_req = "R3";
        do_rd(2, 0, 16'h1234);
        cur_req = "R5";
        do_wr(1, 5, 0, 1'b0);
        cur_req = "R6";
        do_wr(2, 5, 16'habcd, 1'b0);
        do_wr(2, 5, 16'h5555, 1'b0);
        cur_req = "R3";
        do_rd(0, 5, 16'h7777);
        cur_req = "R8";
        send(IN_WB_DATA, 0, 3, 16'hbeef);
        send(IN_INV_ACK, 1, 3, 0);
        send(IN_FLUSH_DATA, 2, 3, 16'hbeef);
        repeat (3) @(negedge clk);
        do_rd(1, 3, 0);
        cur_req = "R4";
        do_wr(0, 5, 0, 1'b1);
        cur_req = "R3";
        do_rd(3, 5, 16'h0f0f);
        cur_req = "R5";
        do_rd(1, 6, 0);
        do_wr(1, 6, 0, 1'b0);
        cur_req = "R4";
        for (int i = 0; i < N_SITES; i++) do_rd(i, 7, 0);
        do_wr(3, 7, 0, 1'b0);
        cur_req = "R10";
        do_rd(0, 7, 16'h2468);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule